// File: doc/BRIEF.md
# Self-Sizing Call Depth Counter

This block holds a small call-depth field, normally a slice of a processor status word, and applies nested-call bookkeeping to it. The width of the active counter is not fixed. It is encoded in the value itself. A run of one bits, starting at the most significant bit, sets aside the upper part of the field. The bits below that run form the counter. A field that is entirely ones turns counting off.

The surrounding pipeline does four things with the block. It loads the field when the status word is written. It asks for an increment when a call is made and a decrement when a return is made. It asks for a zero test before a return from an exception. The block keeps the field, answers each request, and signals overflow and underflow as one-cycle pulses. The pipeline turns those pulses into traps.

A separate enable input gates counting. When the enable is clear, increments and decrements are dropped. The control pins are plain single-cycle strobes. They carry no data stream, so there is no back-pressure.

Top module: `depth_ctr_field`

## Requirements
- R1: After reset the field equals parameter RESET_VAL (default 0), and ovf_o, unf_o and zt_valid_o are low.
- R2: ld_en=1 makes fld_q equal to ld_val on the next clock edge. This overrides any increment or decrement in the same cycle, and no flag is raised for that cycle.
- R3: When the field is all ones, an increment or decrement leaves it unchanged and raises no flag, and a zero test reports zero.
- R4: The counter is the low W-L bits of the field. L is the number of consecutive one bits counted from bit W-1 downward, so L ranges from 0 to W.
- R5: With cnt_en=1, an increment adds one to the field. If the counter of that new value, taken with its own L, is zero, the field keeps its old value and ovf_o is high for the next cycle.
- R6: With cnt_en=1, a decrement whose current counter is zero leaves the field unchanged and makes unf_o high for the next cycle. Otherwise the field drops by one.
- R7: zt_req=1 gives zt_valid_o=1 on the next cycle. In that cycle zt_zero_o is 1 exactly when the field at the request was all ones or had a zero counter.
- R8: With cnt_en=0, inc_req and dec_req do not change the field and raise no flag.
- R9: ovf_o and unf_o are high only in the cycle right after the request that caused them. With no request they return low.
- R10: If inc_req and dec_req are both high, only the increment is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Depth-count enable; gates increment and decrement |
| ld_en | input | 1 | Load strobe for the field |
| ld_val | input | W | Value to load |
| inc_req | input | 1 | Increment request (call) |
| dec_req | input | 1 | Decrement request (return) |
| zt_req | input | 1 | Zero-test request |
| fld_q | output | W | Current field value |
| ovf_o | output | 1 | One-cycle overflow pulse |
| unf_o | output | 1 | One-cycle underflow pulse |
| zt_valid_o | output | 1 | Zero-test result valid |
| zt_zero_o | output | 1 | Zero-test result |

## Verification
The bench builds the block with its default width W=7. At that width the field has only 128 values, so every one of them can be loaded and then hit with an increment, a decrement, a zero test, and a disabled increment and decrement. That sweep reaches every counter width from seven bits down to none. It also covers each carry that crosses into the leading-ones run, and the all-ones disabled code. The expected results come from an arithmetic model in the bench that counts leading ones and takes the value modulo a power of two.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_INC  = 2'd2,
    ACT_DEC  = 2'd3
  } dcf_act_e;
endpackage

// File: rtl/dcf_lead_ones.sv
module dcf_lead_ones #(
  parameter int W  = 7,
  parameter int LW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [LW-1:0] lead
);
  // run[i] is high while every bit from W-1 down to i is one
  logic [W:0] run;
  assign run[W] = 1'b1;
  for (genvar g = W - 1; g >= 0; g--) begin : g_run
    assign run[g] = run[g+1] & val[g];
  end
  assign lead = LW'($countones(run[W-1:0]));
endmodule

// File: rtl/dcf_count_mask.sv
module dcf_count_mask #(
  parameter int W  = 7,
  parameter int LW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  input  logic [LW-1:0] lead,
  output logic          cnt_zero
);
  logic [W-1:0] mask;
  for (genvar g = 0; g < W; g++) begin : g_mask
    assign mask[g] = (32'(g) + 32'(lead)) < 32'(W);
  end
  assign cnt_zero = ((val & mask) == '0);
endmodule

// File: rtl/depth_ctr_field.sv
module depth_ctr_field #(
  parameter int W = 7,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         inc_req,
  input  logic         dec_req,
  input  logic         zt_req,
  output logic [W-1:0] fld_q,
  output logic         ovf_o,
  output logic         unf_o,
  output logic         zt_valid_o,
  output logic         zt_zero_o
);
  import dcf_pkg::*;
  localparam int LW = $clog2(W + 1);

  logic [W-1:0]  fld_r;
  logic [W-1:0]  fld_inc;
  logic [W-1:0]  fld_dec;
  logic [LW-1:0] lead_cur;
  logic [LW-1:0] lead_inc;
  logic          zero_cur;
  logic          zero_inc;
  logic          disabled;
  dcf_act_e      act;

  assign fld_inc  = fld_r + W'(1);
  assign fld_dec  = fld_r - W'(1);
  assign disabled = &fld_r;

  dcf_lead_ones #(.W(W), .LW(LW)) u_lead_cur (.val(fld_r),   .lead(lead_cur));
  dcf_lead_ones #(.W(W), .LW(LW)) u_lead_inc (.val(fld_inc), .lead(lead_inc));
  dcf_count_mask #(.W(W), .LW(LW)) u_mask_cur (.val(fld_r),   .lead(lead_cur), .cnt_zero(zero_cur));
  dcf_count_mask #(.W(W), .LW(LW)) u_mask_inc (.val(fld_inc), .lead(lead_inc), .cnt_zero(zero_inc));

  always_comb begin
    if (ld_en)                               act = ACT_LOAD;
    else if (cnt_en && !disabled && inc_req) act = ACT_INC;
    else if (cnt_en && !disabled && dec_req) act = ACT_DEC;
    else                                     act = ACT_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld_r      <= RESET_VAL;
      ovf_o      <= 1'b0;
      unf_o      <= 1'b0;
      zt_valid_o <= 1'b0;
      zt_zero_o  <= 1'b0;
    end else begin
      ovf_o      <= 1'b0;
      unf_o      <= 1'b0;
      zt_valid_o <= zt_req;
      zt_zero_o  <= zt_req & (disabled | zero_cur);
      case (act)
        ACT_LOAD: fld_r <= ld_val;
        ACT_INC: begin
          if (zero_inc) ovf_o <= 1'b1;
          else          fld_r <= fld_inc;
        end
        ACT_DEC: begin
          if (zero_cur) unf_o <= 1'b1;
          else          fld_r <= fld_dec;
        end
        default: ;
      endcase
    end
  end

  assign fld_q = fld_r;
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int W = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         ld_en,
  input logic [W-1:0] ld_val,
  input logic         inc_req,
  input logic         dec_req,
  input logic         zt_req,
  input logic [W-1:0] fld_q,
  input logic         ovf_o,
  input logic         unf_o,
  input logic         zt_valid_o
);
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n) ld_en |=> (fld_q == $past(ld_val)) && !ovf_o && !unf_o); // R2
  AST_ALLONES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) ((&fld_q) && !ld_en) |=> (&fld_q) && !ovf_o && !unf_o); // R3
  AST_OVF_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (!ld_en && cnt_en && inc_req && !(&fld_q)) |=> (ovf_o ? (fld_q == $past(fld_q)) : (fld_q == W'($past(fld_q) + W'(1))))); // R5
  AST_UNF_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) unf_o |-> (fld_q == $past(fld_q))); // R6
  AST_ZT_ANSWER: assert property (@(posedge clk) disable iff (!rst_n) zt_req |=> zt_valid_o); // R7
  AST_NO_COUNT_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!cnt_en && !ld_en) |=> $stable(fld_q) && !ovf_o && !unf_o); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(inc_req || dec_req) |=> !ovf_o && !unf_o); // R9
  AST_INC_WINS: assert property (@(posedge clk) disable iff (!rst_n) (!ld_en && cnt_en && inc_req && dec_req) |=> !unf_o); // R10
endmodule

bind depth_ctr_field dcf_checker #(.W(W)) u_dcf_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ld_en(ld_en), .ld_val(ld_val),
  .inc_req(inc_req), .dec_req(dec_req), .zt_req(zt_req), .fld_q(fld_q),
  .ovf_o(ovf_o), .unf_o(unf_o), .zt_valid_o(zt_valid_o)
);

// File: tb/tb_depth_ctr_field.sv
`timescale 1ns/1ps
module tb_depth_ctr_field;
  localparam int W = 7;
  localparam int TOP = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, ld_en = 1'b0, inc_req = 1'b0, dec_req = 1'b0, zt_req = 1'b0;
  logic [W-1:0] ld_val = '0;
  logic [W-1:0] fld_q;
  logic ovf_o, unf_o, zt_valid_o, zt_zero_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  depth_ctr_field #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ld_en(ld_en), .ld_val(ld_val),
    .inc_req(inc_req), .dec_req(dec_req), .zt_req(zt_req), .fld_q(fld_q),
    .ovf_o(ovf_o), .unf_o(unf_o), .zt_valid_o(zt_valid_o), .zt_zero_o(zt_zero_o)
  );

  function automatic int lead_ones(int v);
    int l = 0;
    while (l < W && (((v >> (W - 1 - l)) & 1) == 1)) l++;
    return l;
  endfunction

  function automatic int count_of(int v);
    return v % (1 << (W - lead_ones(v)));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(bit ld, int v, bit inc, bit dec, bit zt, bit en);
    @(negedge clk);
    ld_en = ld; ld_val = W'(v); inc_req = inc; dec_req = dec; zt_req = zt; cnt_en = en;
    @(posedge clk);
    #1;
  endtask

  task automatic load(int v);
    drive(1'b1, v, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 field", int'(fld_q), 0);
    chk("R1 flags", int'({ovf_o, unf_o, zt_valid_o}), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v <= TOP; v++) begin
      int n, ef, eo;
      // increment
      load(v);
      chk("R2 load", int'(fld_q), v);
      drive(1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b1);
      if (v == TOP) begin ef = v; eo = 0; end
      else begin
        n = v + 1;
        if (count_of(n) == 0) begin ef = v; eo = 1; end
        else begin ef = n; eo = 0; end
      end
      chk(v == TOP ? "R3 inc field" : "R5 R4 inc field", int'(fld_q), ef);
      chk("R5 ovf", int'(ovf_o), eo);
      drive(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R9 ovf clears", int'(ovf_o), 0);
      // decrement
      load(v);
      drive(1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b1);
      if (v == TOP) begin ef = v; eo = 0; end
      else if (count_of(v) == 0) begin ef = v; eo = 1; end
      else begin ef = v - 1; eo = 0; end
      chk(v == TOP ? "R3 dec field" : "R6 R4 dec field", int'(fld_q), ef);
      chk("R6 unf", int'(unf_o), eo);
      drive(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R9 unf clears", int'(unf_o), 0);
      // zero test
      load(v);
      drive(1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b1);
      chk("R7 zt valid", int'(zt_valid_o), 1);
      chk("R7 zt zero", int'(zt_zero_o), (v == TOP || count_of(v) == 0) ? 1 : 0);
      // disabled counting
      drive(1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R8 inc off", int'({fld_q, ovf_o, unf_o}), v << 2);
      drive(1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
      chk("R8 dec off", int'({fld_q, ovf_o, unf_o}), v << 2);
      // both requests: increment only
      drive(1'b0, 0, 1'b1, 1'b1, 1'b0, 1'b1);
      if (v == TOP) ef = v;
      else if (count_of(v + 1) == 0) ef = v;
      else ef = v + 1;
      chk("R10 both", int'(fld_q), ef);
      chk("R10 no unf", int'(unf_o), 0);
      // load overrides a request
      drive(1'b1, (v + 5) % (TOP + 1), 1'b1, 1'b0, 1'b0, 1'b1);
      chk("R2 load wins", int'({fld_q, ovf_o}), ((v + 5) % (TOP + 1)) << 1);
    end
    drive(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 zt idle", int'(zt_valid_o), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule